// File: doc/BRIEF.md
# Repeater Expansion Port Interface

This block joins one multi-port repeater core to a shared expansion bus, so that several repeater devices can be stacked beneath an external arbiter. On the core side it collects a forced-jam request from every port together with an internal collision flag. It merges them into one active-high jam line toward the arbiter. It also turns a filtered external jam command into a jam-all-ports order for the core.

Two arbiter inputs are deglitched before use: the external jam and the active-low bus grant. Each passes through a synchronizer and then a stability filter. A change is accepted only after a set number of equal consecutive samples. With a 25 MHz sample clock, two samples cover the 40 ns window. When the core wants to send, the block raises a request toward the arbiter. Once a filtered grant is held, it drives 5-bit symbols onto the bus and emits a forwarded data clock at half the sample rate. Each symbol occupies two cycles, and a take strobe tells the core when to move to the next one.

On the receive side, the block synchronizes a neighbour's forwarded clock, carrier sense and data. It captures one symbol on each rising clock edge seen while carrier sense is high.

Top module: `xport_link`

## Requirements
- R1: `jam_o` is high whenever any bit of `port_jam_i` is high. While the filtered external jam is inactive, it is also high whenever `core_coll_i` is high. Otherwise it is low.
- R2: While the filtered external jam is active (`jam_all_o` high), `core_coll_i` has no effect on `jam_o`. The port jam bits still drive it.
- R3: `jam_all_o` rises at the clock edge numbered SYNC_STAGES+FILT_LEN, counted from the first edge that samples `ext_jam_i` high, provided `ext_jam_i` stays high for at least FILT_LEN samples. It falls in the same way after `ext_jam_i` goes low.
- R4: A pulse on `ext_jam_i` or `arb_grant_ni` that lasts fewer than FILT_LEN samples changes neither `jam_all_o`, `exp_act_o` nor `bus_oe_o`.
- R5: `exp_act_o` goes high with the same latency as R3 after `arb_grant_ni` goes low (grant active low). It falls with that latency after `arb_grant_ni` returns high.
- R6: `bus_oe_o` is high exactly when the filtered grant is held and `tx_req_i` is high. It drops in the same cycle that either condition ends. `bus_d_o` equals `tx_sym_i` while `bus_oe_o` is high and is all zeros otherwise.
- R7: `exp_clk_o` is low whenever `bus_oe_o` is low. In the first driving cycle it is low, and it then toggles every cycle while driving continues.
- R8: `tx_take_o` is high exactly in the driving cycles in which `exp_clk_o` is high, so it is never high for two cycles in a row. The core advances `tx_sym_i` after each such cycle.
- R9: `any_act_o` follows `tx_req_i` in the same cycle, whether or not a grant is held.
- R10: If `exp_clk_i` is sampled rising while `bus_crs_i` is high, `rx_valid_o` is high for exactly one cycle, after the third clock edge counted from the sample. In that cycle `rx_sym_o` holds the `bus_d_i` value taken in the same sample.
- R11: Rising edges on `exp_clk_i` sampled while `bus_crs_i` is low produce no `rx_valid_o`. `rx_crs_o` is `bus_crs_i` delayed by SYNC_STAGES edges.
- R12: During and right after reset, `jam_o`, `jam_all_o`, `exp_act_o`, `bus_oe_o`, `exp_clk_o`, `tx_take_o`, `rx_valid_o` are low and `bus_d_o` is zero, given idle inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local sample clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| port_jam_i | input | NPORTS | Forced-jam request per repeater port |
| core_coll_i | input | 1 | Collision flag from the repeater core |
| jam_o | output | 1 | Merged jam toward the arbiter |
| ext_jam_i | input | 1 | External jam command from the arbiter |
| jam_all_o | output | 1 | Filtered command to jam every port |
| arb_grant_ni | input | 1 | Bus grant from the arbiter, active low |
| exp_act_o | output | 1 | Filtered grant seen |
| tx_req_i | input | 1 | Core has symbols to send |
| tx_sym_i | input | SYM_W | Symbol to send |
| tx_take_o | output | 1 | Current symbol consumed this cycle |
| any_act_o | output | 1 | Request toward the arbiter |
| bus_d_o | output | SYM_W | Expansion data, driven value |
| bus_oe_o | output | 1 | Output enable for the expansion data |
| exp_clk_o | output | 1 | Forwarded data clock |
| bus_d_i | input | SYM_W | Expansion data, sampled value |
| bus_crs_i | input | 1 | Expansion carrier sense |
| exp_clk_i | input | 1 | Neighbour's forwarded data clock |
| rx_sym_o | output | SYM_W | Captured received symbol |
| rx_valid_o | output | 1 | Received symbol strobe |
| rx_crs_o | output | 1 | Synchronized carrier sense |

## Verification
The bench builds the block with NPORTS=4, SYM_W=5, SYNC_STAGES=2 and FILT_LEN=3, not the default filter length of two. This makes the filter latency five edges. It also leaves room for a two-sample pulse that must be rejected while still spanning more than one sample, which tests the counter limit rather than only the synchronizer. With four ports, each port jam bit can be walked singly. Setting the filter longer than the synchronizer also keeps a wrong stage count from passing by coincidence.

// File: rtl/xport_pkg.sv
package xport_pkg;

  localparam int unsigned DEF_NPORTS      = 8;
  localparam int unsigned DEF_SYM_W       = 5;
  localparam int unsigned DEF_SYNC_STAGES = 2;
  localparam int unsigned DEF_FILT_LEN    = 2;

  // Phase of the forwarded clock while the bus is driven.
  typedef enum logic {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } clk_phase_e;

  // Width of a counter that must hold values 0..limit.
  function automatic int unsigned cnt_width(input int unsigned limit);
    int unsigned w;
    w = 1;
    while ((1 << w) <= limit) w++;
    return w;
  endfunction

endpackage

// File: rtl/xport_deglitch.sv
module xport_deglitch #(
  parameter int unsigned SYNC_STAGES = xport_pkg::DEF_SYNC_STAGES,
  parameter int unsigned FILT_LEN    = xport_pkg::DEF_FILT_LEN,
  parameter logic        RST_VAL     = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic filt_o
);

  localparam int unsigned CW = xport_pkg::cnt_width(FILT_LEN);
  localparam logic [CW-1:0] CNT_LAST = CW'(FILT_LEN - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   samp;
  logic                   filt_q, filt_d;
  logic [CW-1:0]          cnt_q, cnt_d;

  // Synchronizer chain; stage 0 takes the raw pin.
  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[0] <= RST_VAL;
        else         sync_q[0] <= raw_i;
      end
    end else begin : g_rest
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[s] <= RST_VAL;
        else         sync_q[s] <= sync_q[s-1];
      end
    end
  end

  assign samp = sync_q[SYNC_STAGES-1];

  // Accept a new level only after FILT_LEN equal samples.
  always_comb begin
    filt_d = filt_q;
    cnt_d  = '0;
    if (samp != filt_q) begin
      if (cnt_q == CNT_LAST) begin
        filt_d = samp;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      filt_q <= RST_VAL;
      cnt_q  <= '0;
    end else begin
      filt_q <= filt_d;
      cnt_q  <= cnt_d;
    end
  end

  assign filt_o = filt_q;

endmodule

// File: rtl/xport_tx.sv
module xport_tx #(
  parameter int unsigned SYM_W = xport_pkg::DEF_SYM_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             grant_i,
  input  logic             req_i,
  input  logic [SYM_W-1:0] sym_i,
  output logic             oe_o,
  output logic [SYM_W-1:0] d_o,
  output logic             clk_o,
  output logic             take_o
);

  import xport_pkg::*;

  logic       drive;
  clk_phase_e phase_q, phase_d;

  // Drive release is combinational so the bus frees in the same cycle.
  assign drive = grant_i & req_i;

  always_comb begin
    phase_d = PH_LOW;
    if (drive) begin
      phase_d = (phase_q == PH_LOW) ? PH_HIGH : PH_LOW;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= PH_LOW;
    else         phase_q <= phase_d;
  end

  assign oe_o   = drive;
  assign d_o    = drive ? sym_i : '0;
  assign clk_o  = drive & (phase_q == PH_HIGH);
  assign take_o = clk_o;

endmodule

// File: rtl/xport_rx.sv
module xport_rx #(
  parameter int unsigned SYM_W       = xport_pkg::DEF_SYM_W,
  parameter int unsigned SYNC_STAGES = xport_pkg::DEF_SYNC_STAGES
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             eclk_i,
  input  logic             crs_i,
  input  logic [SYM_W-1:0] d_i,
  output logic [SYM_W-1:0] sym_o,
  output logic             valid_o,
  output logic             crs_o
);

  localparam int unsigned BW = SYM_W + 2;

  logic [BW-1:0] stage_q [SYNC_STAGES];
  logic [BW-1:0] bundle_in, bundle_s;
  logic          eclk_s, crs_s, eclk_prev_q;
  logic [SYM_W-1:0] d_s;
  logic          cap;
  logic [SYM_W-1:0] sym_q, sym_d;
  logic          valid_q, valid_d;

  assign bundle_in = {eclk_i, crs_i, d_i};

  // Clock, carrier sense and data share one synchronizer depth.
  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[0] <= '0;
        else         stage_q[0] <= bundle_in;
      end
    end else begin : g_rest
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign bundle_s = stage_q[SYNC_STAGES-1];
  assign eclk_s   = bundle_s[BW-1];
  assign crs_s    = bundle_s[BW-2];
  assign d_s      = bundle_s[SYM_W-1:0];

  assign cap = eclk_s & ~eclk_prev_q & crs_s;

  always_comb begin
    sym_d   = sym_q;
    valid_d = cap;
    if (cap) sym_d = d_s;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eclk_prev_q <= 1'b0;
      sym_q       <= '0;
      valid_q     <= 1'b0;
    end else begin
      eclk_prev_q <= eclk_s;
      sym_q       <= sym_d;
      valid_q     <= valid_d;
    end
  end

  assign sym_o   = sym_q;
  assign valid_o = valid_q;
  assign crs_o   = crs_s;

endmodule

// File: rtl/xport_link.sv
module xport_link #(
  parameter int unsigned NPORTS      = xport_pkg::DEF_NPORTS,
  parameter int unsigned SYM_W       = xport_pkg::DEF_SYM_W,
  parameter int unsigned SYNC_STAGES = xport_pkg::DEF_SYNC_STAGES,
  parameter int unsigned FILT_LEN    = xport_pkg::DEF_FILT_LEN
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NPORTS-1:0] port_jam_i,
  input  logic              core_coll_i,
  output logic              jam_o,
  input  logic              ext_jam_i,
  output logic              jam_all_o,
  input  logic              arb_grant_ni,
  output logic              exp_act_o,
  input  logic              tx_req_i,
  input  logic [SYM_W-1:0]  tx_sym_i,
  output logic              tx_take_o,
  output logic              any_act_o,
  output logic [SYM_W-1:0]  bus_d_o,
  output logic              bus_oe_o,
  output logic              exp_clk_o,
  input  logic [SYM_W-1:0]  bus_d_i,
  input  logic              bus_crs_i,
  input  logic              exp_clk_i,
  output logic [SYM_W-1:0]  rx_sym_o,
  output logic              rx_valid_o,
  output logic              rx_crs_o
);

  logic [1:0] rst_pipe_q;
  logic       rst_n_int;
  logic       ext_jam_f;
  logic       grant_n_f;
  logic       grant_f;

  // Reset asserts at once and releases on a clock edge.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_pipe_q <= 2'b00;
    else         rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_int = rst_pipe_q[1];

  xport_deglitch #(
    .SYNC_STAGES(SYNC_STAGES),
    .FILT_LEN   (FILT_LEN),
    .RST_VAL    (1'b0)
  ) jam_filt_i (
    .clk_i (clk_i),
    .rst_ni(rst_n_int),
    .raw_i (ext_jam_i),
    .filt_o(ext_jam_f)
  );

  xport_deglitch #(
    .SYNC_STAGES(SYNC_STAGES),
    .FILT_LEN   (FILT_LEN),
    .RST_VAL    (1'b1)
  ) grant_filt_i (
    .clk_i (clk_i),
    .rst_ni(rst_n_int),
    .raw_i (arb_grant_ni),
    .filt_o(grant_n_f)
  );

  assign grant_f   = ~grant_n_f;
  assign jam_all_o = ext_jam_f;
  assign exp_act_o = grant_f;

  // Core collisions while the arbiter jams us are its echo: mask them.
  assign jam_o = (|port_jam_i) | (core_coll_i & ~ext_jam_f);

  assign any_act_o = tx_req_i;

  xport_tx #(
    .SYM_W(SYM_W)
  ) tx_i (
    .clk_i  (clk_i),
    .rst_ni (rst_n_int),
    .grant_i(grant_f),
    .req_i  (tx_req_i),
    .sym_i  (tx_sym_i),
    .oe_o   (bus_oe_o),
    .d_o    (bus_d_o),
    .clk_o  (exp_clk_o),
    .take_o (tx_take_o)
  );

  xport_rx #(
    .SYM_W      (SYM_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) rx_i (
    .clk_i  (clk_i),
    .rst_ni (rst_n_int),
    .eclk_i (exp_clk_i),
    .crs_i  (bus_crs_i),
    .d_i    (bus_d_i),
    .sym_o  (rx_sym_o),
    .valid_o(rx_valid_o),
    .crs_o  (rx_crs_o)
  );

endmodule

// File: rtl/xport_link_chk.sv
module xport_link_chk #(
  parameter int unsigned NPORTS = 8,
  parameter int unsigned SYM_W  = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NPORTS-1:0] port_jam_i,
  input logic              core_coll_i,
  input logic              jam_o,
  input logic              jam_all_o,
  input logic              exp_act_o,
  input logic              tx_req_i,
  input logic              tx_take_o,
  input logic              any_act_o,
  input logic [SYM_W-1:0]  bus_d_o,
  input logic              bus_oe_o,
  input logic              exp_clk_o,
  input logic              rx_valid_o
);

  // R1: any port jam reaches the arbiter
  a_r1_port_jam_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|port_jam_i) |-> jam_o);

  // R2: core collisions are not echoed while jammed from outside
  a_r2_no_echo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (jam_all_o && !(|port_jam_i)) |-> !jam_o);

  // R6: the bus is driven only with a grant and a request
  a_r6_oe_needs_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_oe_o |-> (exp_act_o && tx_req_i));

  // R6: idle data is zero
  a_r6_idle_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_oe_o |-> (bus_d_o == '0));

  // R7: forwarded clock is quiet when not driving
  a_r7_clk_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_oe_o |-> !exp_clk_o);

  // R7: first driving cycle starts low
  a_r7_clk_first_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_oe_o) |-> !exp_clk_o);

  // R8: take never stays high for two cycles
  a_r8_take_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_take_o |=> !tx_take_o);

  // R9: request follows the core
  a_r9_any_act: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_act_o == tx_req_i);

  // R10: receive strobe lasts one cycle
  a_r10_rx_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);

endmodule

bind xport_link xport_link_chk #(
  .NPORTS(NPORTS),
  .SYM_W (SYM_W)
) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .port_jam_i (port_jam_i),
  .core_coll_i(core_coll_i),
  .jam_o      (jam_o),
  .jam_all_o  (jam_all_o),
  .exp_act_o  (exp_act_o),
  .tx_req_i   (tx_req_i),
  .tx_take_o  (tx_take_o),
  .any_act_o  (any_act_o),
  .bus_d_o    (bus_d_o),
  .bus_oe_o   (bus_oe_o),
  .exp_clk_o  (exp_clk_o),
  .rx_valid_o (rx_valid_o)
);

// File: tb/xport_link_tb.sv
module xport_link_tb_top;

  localparam int unsigned NP   = 4;
  localparam int unsigned SW   = 5;
  localparam int unsigned SYNC = 2;
  localparam int unsigned FL   = 3;
  localparam int unsigned LAT  = SYNC + FL;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NP-1:0] port_jam;
  logic          core_coll;
  logic          jam;
  logic          ext_jam;
  logic          jam_all;
  logic          grant_n;
  logic          exp_act;
  logic          tx_req;
  logic [SW-1:0] tx_sym;
  logic          tx_take;
  logic          any_act;
  logic [SW-1:0] bus_d_o;
  logic          bus_oe;
  logic          eclk_o;
  logic [SW-1:0] bus_d_i;
  logic          bus_crs;
  logic          eclk_i;
  logic [SW-1:0] rx_sym;
  logic          rx_valid;
  logic          rx_crs;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  xport_link #(
    .NPORTS(NP), .SYM_W(SW), .SYNC_STAGES(SYNC), .FILT_LEN(FL)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .port_jam_i(port_jam), .core_coll_i(core_coll),
    .jam_o(jam), .ext_jam_i(ext_jam), .jam_all_o(jam_all),
    .arb_grant_ni(grant_n), .exp_act_o(exp_act), .tx_req_i(tx_req),
    .tx_sym_i(tx_sym), .tx_take_o(tx_take), .any_act_o(any_act),
    .bus_d_o(bus_d_o), .bus_oe_o(bus_oe), .exp_clk_o(eclk_o),
    .bus_d_i(bus_d_i), .bus_crs_i(bus_crs), .exp_clk_i(eclk_i),
    .rx_sym_o(rx_sym), .rx_valid_o(rx_valid), .rx_crs_o(rx_crs)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_sim();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; port_jam = '0; core_coll = 0; ext_jam = 0; grant_n = 1;
    tx_req = 0; tx_sym = '0; bus_d_i = '0; bus_crs = 0; eclk_i = 0;
    repeat (3) @(negedge clk);
    chk("R12 jam", jam, 0);       chk("R12 jam_all", jam_all, 0);
    chk("R12 exp_act", exp_act, 0); chk("R12 oe", bus_oe, 0);
    chk("R12 eclk", eclk_o, 0);   chk("R12 rx_valid", rx_valid, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R12 take after", tx_take, 0); chk("R12 data after", bus_d_o, 0);
    chk("R12 jam_all after", jam_all, 0);
  endtask

  task automatic t_jam_merge();
    @(negedge clk);
    for (int i = 0; i < NP; i++) begin
      port_jam = NP'(1) << i; #1;
      chk("R1 port bit", jam, 1);
      @(negedge clk);
    end
    port_jam = '0; #1; chk("R1 none", jam, 0);
    core_coll = 1; #1; chk("R1 core coll", jam, 1);
    core_coll = 0; #1; chk("R1 core clear", jam, 0);
  endtask

  task automatic t_ext_jam();
    @(negedge clk);
    ext_jam = 1; repeat (FL - 1) @(negedge clk); ext_jam = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); chk("R4 short jam pulse", jam_all, 0);
    end
    ext_jam = 1;
    repeat (LAT - 1) @(negedge clk); chk("R3 jam before latency", jam_all, 0);
    @(negedge clk); chk("R3 jam at latency", jam_all, 1);
    core_coll = 1; #1; chk("R2 collision masked", jam, 0);
    port_jam = 4'b0100; #1; chk("R2 port jam passes", jam, 1);
    port_jam = '0; core_coll = 0;
    @(negedge clk); ext_jam = 0;
    repeat (LAT - 1) @(negedge clk); chk("R3 release before latency", jam_all, 1);
    @(negedge clk); chk("R3 release at latency", jam_all, 0);
    core_coll = 1; #1; chk("R1 collision after release", jam, 1);
    core_coll = 0;
  endtask

  task automatic t_short_grant();
    @(negedge clk);
    tx_req = 1; tx_sym = 5'h13;
    grant_n = 0; repeat (FL - 1) @(negedge clk); grant_n = 1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk("R4 short grant exp_act", exp_act, 0);
      chk("R4 short grant oe", bus_oe, 0);
    end
    chk("R9 request without grant", any_act, 1);
    tx_req = 0; #1; chk("R9 request drop", any_act, 0);
  endtask

  task automatic t_grant();
    @(negedge clk);
    grant_n = 0;
    repeat (LAT - 1) @(negedge clk); chk("R5 grant before latency", exp_act, 0);
    @(negedge clk); chk("R5 grant at latency", exp_act, 1);
    chk("R6 no drive without request", bus_oe, 0);
  endtask

  task automatic t_transmit();
    @(negedge clk);
    tx_sym = 5'h15; tx_req = 1; #1;
    chk("R6 oe on", bus_oe, 1); chk("R6 data", bus_d_o, 5'h15);
    chk("R7 first low", eclk_o, 0); chk("R8 no take first", tx_take, 0);
    chk("R9 request", any_act, 1);
    @(negedge clk);
    chk("R7 high", eclk_o, 1); chk("R8 take", tx_take, 1);
    @(negedge clk);
    tx_sym = 5'h0A; #1;
    chk("R7 low again", eclk_o, 0); chk("R8 take off", tx_take, 0);
    chk("R6 next data", bus_d_o, 5'h0A);
    @(negedge clk);
    chk("R7 high again", eclk_o, 1); chk("R8 take again", tx_take, 1);
    tx_req = 0; #1;
    chk("R6 oe off same cycle", bus_oe, 0); chk("R6 data zero", bus_d_o, 0);
    chk("R7 clock gated", eclk_o, 0); chk("R8 take gated", tx_take, 0);
    @(negedge clk);
    tx_req = 1; #1; chk("R7 restart low", eclk_o, 0);
  endtask

  task automatic t_grant_drop();
    @(negedge clk);
    grant_n = 1;
    repeat (LAT - 1) @(negedge clk); chk("R6 still driving", bus_oe, 1);
    @(negedge clk);
    chk("R6 oe off with grant", bus_oe, 0); chk("R5 exp_act off", exp_act, 0);
    chk("R7 clock off", eclk_o, 0); chk("R9 request held", any_act, 1);
    tx_req = 0;
  endtask

  task automatic t_receive();
    @(negedge clk);
    bus_crs = 1;
    repeat (SYNC) @(negedge clk);
    chk("R11 crs synced", rx_crs, 1);
    eclk_i = 1; bus_d_i = 5'h1B;
    @(negedge clk); eclk_i = 0; bus_d_i = 5'h04;
    @(negedge clk); chk("R10 not yet", rx_valid, 0);
    @(negedge clk); chk("R10 valid", rx_valid, 1); chk("R10 symbol", rx_sym, 5'h1B);
    @(negedge clk); chk("R10 one cycle", rx_valid, 0);
    bus_crs = 0;
    repeat (SYNC + 1) @(negedge clk);
    chk("R11 crs low", rx_crs, 0);
    eclk_i = 1; bus_d_i = 5'h07;
    @(negedge clk); eclk_i = 0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); chk("R11 no capture without crs", rx_valid, 0);
    end
    chk("R11 symbol kept", rx_sym, 5'h1B);
  endtask

  initial begin
    t_reset();
    t_jam_merge();
    t_ext_jam();
    t_short_grant();
    t_grant();
    t_transmit();
    t_grant_drop();
    t_receive();
    finish_sim();
  end

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_sim();
  end

endmodule